// File: doc/BRIEF.md
# Predicate-count saturating scalar decrementer

This block takes a vector predicate and a scalar operand and returns the operand reduced by the number of active predicate elements, clamped so that it never goes below zero. The predicate has one bit per byte of the vector. A two-bit size code sets how those bits group into elements. Only the lowest bit of each group decides whether that element is active.

A mode bit selects 32-bit or 64-bit unsigned arithmetic. In 32-bit mode the upper half of the operand is dropped before the subtraction, and the result is zero-extended to 64 bits. The vector length is a parameter: a multiple of 128 bits from 128 to 2048.

Each request is a single-cycle strobe. The result, a valid flag and a flag that marks a clamp to zero appear one clock cycle later. A synchronous active-high reset clears all three.

Top module: `pcnt_sat_dec`

## Requirements
- R1: The size code `elemSize` gives an element of 8 << elemSize bits (0: byte, 1: halfword, 2: word, 3: doubleword). The element count is the number of predicate bits set at indices e × 2^elemSize. All other predicate bits have no effect.
- R2: With `elemSize` = 0, every predicate bit is one element. An all-ones predicate gives a count of VEC_BITS/8.
- R3: With `wide` = 0, only operand bits 31:0 take part, and result bits 63:32 are zero. Operand bits 63:32 do not affect the result.
- R4: With `wide` = 1, the full 64-bit operand minus the count is returned unchanged whenever it does not go below zero.
- R5: When the count exceeds the masked operand, the result is 0 and `satFlag` is 1. Otherwise `satFlag` is 0, including the case where the count equals the operand exactly.
- R6: `outVld` is high in exactly the cycle after a cycle in which `inVld` was high.
- R7: A cycle with `rst` high makes `outVld`, `result` and `satFlag` zero on the next edge.
- R8: `result` and `satFlag` keep their values in any cycle that follows a cycle without `inVld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inVld | input | 1 | Request strobe |
| pred | input | VEC_BITS/8 | Predicate, one bit per vector byte |
| elemSize | input | 2 | Element size code |
| wide | input | 1 | 0: 32-bit arithmetic, 1: 64-bit arithmetic |
| operand | input | 64 | Scalar operand |
| outVld | output | 1 | Result valid |
| result | output | 64 | Saturated, zero-extended difference |
| satFlag | output | 1 | Set when the result was clamped to zero |

## Verification
The hardest case to reach is the saturation boundary: a count equal to the operand must give zero with no clamp flag, while one more active element must set the flag. Table vectors build that boundary from sparse predicates whose active bits land exactly on the group's lowest index for the larger element sizes. Other vectors set bits only at odd positions, so they fall inside a group and must be ignored. In 32-bit mode the upper operand half is loaded with non-zero patterns, so a leak into the low half or into the upper result bits would be visible at the port.

// File: rtl/pcsd_pkg.sv
package pcsd_pkg;
  // Strobes sent from control to the datapath.
  typedef struct packed {
    logic load;   // capture a new result this edge
  } dpStrobeT;
endpackage

// File: rtl/pcsd_counter.sv
module pcsd_counter #(
  parameter int VEC_BITS = 256,
  localparam int PRED_BITS = VEC_BITS / 8,
  localparam int CNT_W = $clog2(PRED_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PRED_BITS-1:0] pred,
  input  logic [1:0]           elemSize,
  output logic [CNT_W-1:0]     count
);
  logic [CNT_W-1:0] cntBySize [4];

  // One popcount per element size; only the group's lowest bit is sampled.
  for (genvar s = 0; s < 4; s++) begin : g_size
    localparam int STRIDE = 1 << s;
    localparam int NEL = PRED_BITS / STRIDE;
    logic [CNT_W-1:0] partial;
    always_comb begin
      partial = '0;
      for (int e = 0; e < NEL; e++) begin
        partial = partial + CNT_W'(pred[e*STRIDE]);
      end
    end
    assign cntBySize[s] = partial;
  end

  assign count = cntBySize[elemSize];

  // R1: count never exceeds the number of elements for this size
  p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
    (32'(count) <= (PRED_BITS >> elemSize)));
endmodule

// File: rtl/pcsd_ctrl.sv
module pcsd_ctrl
  import pcsd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     inVld,
  output dpStrobeT strobe,
  output logic     outVld
);
  assign strobe.load = inVld & ~rst;

  always_ff @(posedge clk) begin
    if (rst) outVld <= 1'b0;
    else     outVld <= inVld;
  end

  p_latency_r6: assert property (@(posedge clk) disable iff (rst)
    inVld |=> outVld);
  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !inVld |=> !outVld);
  p_reset_clear_r7: assert property (@(posedge clk)
    rst |=> !outVld);
endmodule

// File: rtl/pcsd_datapath.sv
module pcsd_datapath
  import pcsd_pkg::*;
#(
  parameter int VEC_BITS = 256,
  localparam int PRED_BITS = VEC_BITS / 8,
  localparam int CNT_W = $clog2(PRED_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  dpStrobeT             strobe,
  input  logic [PRED_BITS-1:0] pred,
  input  logic [1:0]           elemSize,
  input  logic                 wide,
  input  logic [63:0]          operand,
  input  logic                 outVld,
  output logic [63:0]          result,
  output logic                 satFlag
);
  logic [CNT_W-1:0] count;
  logic [63:0]      opMasked;
  logic [63:0]      cntWide;
  logic [63:0]      diff;
  logic             under;
  logic             wideQ;

  pcsd_counter #(.VEC_BITS(VEC_BITS)) i_counter (
    .clk      (clk),
    .rst      (rst),
    .pred     (pred),
    .elemSize (elemSize),
    .count    (count)
  );

  always_comb begin
    opMasked = wide ? operand : {32'b0, operand[31:0]};
    cntWide  = 64'(count);
    under    = cntWide > opMasked;
    diff     = under ? 64'b0 : (opMasked - cntWide);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      satFlag <= 1'b0;
      wideQ   <= 1'b0;
    end else if (strobe.load) begin
      result  <= diff;
      satFlag <= under;
      wideQ   <= wide;
    end
  end

  p_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (outVld && !wideQ) |-> (result[63:32] == 32'b0));
  p_no_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (outVld && wideQ && !satFlag) |-> (result <= $past(operand)));
  p_sat_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (outVld && satFlag) |-> (result == 64'b0));
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(strobe.load) |-> ($stable(result) && $stable(satFlag)));
endmodule

// File: rtl/pcnt_sat_dec.sv
module pcnt_sat_dec
  import pcsd_pkg::*;
#(
  parameter int VEC_BITS = 256,
  localparam int PRED_BITS = VEC_BITS / 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inVld,
  input  logic [PRED_BITS-1:0] pred,
  input  logic [1:0]           elemSize,
  input  logic                 wide,
  input  logic [63:0]          operand,
  output logic                 outVld,
  output logic [63:0]          result,
  output logic                 satFlag
);
  dpStrobeT strobe;

  pcsd_ctrl i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .inVld  (inVld),
    .strobe (strobe),
    .outVld (outVld)
  );

  pcsd_datapath #(.VEC_BITS(VEC_BITS)) i_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .pred     (pred),
    .elemSize (elemSize),
    .wide     (wide),
    .operand  (operand),
    .outVld   (outVld),
    .result   (result),
    .satFlag  (satFlag)
  );
endmodule

// File: tb/test_pcnt_sat_dec.sv
module test_pcnt_sat_dec;
  localparam int VB = 256;
  localparam int PB = VB / 8;
  localparam int NV = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inVld = 1'b0;
  logic [PB-1:0] pred = '0;
  logic [1:0]    elemSize = '0;
  logic          wide = 1'b0;
  logic [63:0]   operand = '0;
  logic          outVld;
  logic [63:0]   result;
  logic          satFlag;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pcnt_sat_dec #(.VEC_BITS(VB)) i_pcnt_sat_dec (
    .clk(clk), .rst(rst), .inVld(inVld), .pred(pred), .elemSize(elemSize),
    .wide(wide), .operand(operand), .outVld(outVld), .result(result),
    .satFlag(satFlag)
  );

  // {pred[31:0], size[1:0], wide, operand[63:0], expResult[63:0], expSat}
  localparam logic [163:0] TBL [NV] = '{
    {32'hFFFFFFFF, 2'd0, 1'b1, 64'd100, 64'd68, 1'b0},                 // R2 all bytes
    {32'hFFFFFFFF, 2'd1, 1'b1, 64'd100, 64'd84, 1'b0},                 // R1 halfword
    {32'hFFFFFFFF, 2'd2, 1'b1, 64'd100, 64'd92, 1'b0},                 // R1 word
    {32'hFFFFFFFF, 2'd3, 1'b1, 64'd100, 64'd96, 1'b0},                 // R1 doubleword
    {32'hAAAAAAAA, 2'd1, 1'b1, 64'd5, 64'd5, 1'b0},                    // R1 odd bits ignored
    {32'hAAAAAAAA, 2'd0, 1'b1, 64'd5, 64'd0, 1'b1},                    // R5 clamp
    {32'h0000000F, 2'd0, 1'b0, 64'hFFFFFFFF_00000003, 64'd0, 1'b1},    // R3 R5
    {32'h00000001, 2'd0, 1'b0, 64'h12345678_00000010, 64'h0F, 1'b0},   // R3
    {32'h00000001, 2'd0, 1'b1, 64'h12345678_00000010, 64'h12345678_0000000F, 1'b0}, // R4
    {32'h00000000, 2'd0, 1'b1, 64'd0, 64'd0, 1'b0},                    // R5 zero/zero
    {32'h00000001, 2'd0, 1'b1, 64'd0, 64'd0, 1'b1},                    // R5 zero operand
    {32'h01010101, 2'd3, 1'b1, 64'd4, 64'd0, 1'b0},                    // R5 exact boundary
    {32'h11111111, 2'd2, 1'b1, 64'hFFFFFFFF_FFFFFFFF, 64'hFFFFFFFF_FFFFFFF7, 1'b0}, // R4
    {32'h11111111, 2'd2, 1'b0, 64'hFFFFFFFF_FFFFFFFF, 64'h00000000_FFFFFFF7, 1'b0}  // R3
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  // Drive one request; return at the following negedge with outputs settled.
  task automatic issue(input logic [PB-1:0] p, input logic [1:0] s,
                       input logic w, input logic [63:0] op);
    @(negedge clk);
    pred = p; elemSize = s; wide = w; operand = op; inVld = 1'b1;
    @(negedge clk);
    inVld = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset outVld", 64'(outVld), 64'd0);
    check("R7 reset result", result, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R6 idle outVld", 64'(outVld), 64'd0);

    for (int i = 0; i < NV; i++) begin
      issue(TBL[i][163:132], TBL[i][131:130], TBL[i][129], TBL[i][128:65]);
      check($sformatf("R6 vec%0d outVld", i), 64'(outVld), 64'd1);
      check($sformatf("R1-table vec%0d result", i), result, TBL[i][64:1]);
      check($sformatf("R5 vec%0d satFlag", i), 64'(satFlag), 64'(TBL[i][0]));
    end

    // R6: valid drops the cycle after a lone strobe
    @(negedge clk);
    check("R6 single pulse", 64'(outVld), 64'd0);

    // R8: inputs change with no strobe; outputs hold
    pred = '1; elemSize = 2'd0; wide = 1'b1; operand = 64'd1;
    repeat (2) @(negedge clk);
    check("R8 hold result", result, 64'h00000000_FFFFFFF7);
    check("R8 hold satFlag", 64'(satFlag), 64'd0);

    // R1: intra-group bits only, doubleword size
    issue(32'hFEFEFEFE, 2'd3, 1'b1, 64'd9);
    check("R1 group bits ignored", result, 64'd9);

    // R5: one more than operand, doubleword size
    issue(32'h01010101, 2'd3, 1'b1, 64'd3);
    check("R5 one past boundary", result, 64'd0);
    check("R5 one past flag", 64'(satFlag), 64'd1);

    // R6: back-to-back strobes
    @(negedge clk);
    pred = 32'h3; elemSize = 2'd0; wide = 1'b1; operand = 64'd10; inVld = 1'b1;
    @(negedge clk);
    check("R6 b2b first", result, 64'd8);
    operand = 64'd20;
    @(negedge clk);
    inVld = 1'b0;
    check("R6 b2b second", result, 64'd18);
    check("R6 b2b valid", 64'(outVld), 64'd1);

    // R7: reset after activity
    issue(32'h1, 2'd0, 1'b1, 64'd50);
    rst = 1'b1;
    @(negedge clk);
    check("R7 mid-run outVld", 64'(outVld), 64'd0);
    check("R7 mid-run result", result, 64'd0);
    rst = 1'b0;

    finished = 1;
    report();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end
endmodule